// File: doc/BRIEF.md
# PCIe Reference PLL Bring-Up Sequencer

This block starts the reference PLL that feeds a PCIe pad and later shuts it down. A one-cycle start request sets off a fixed chain of register steps. First the reference-clock select field is cleared. Next the three clock-enable bits are raised. Then the PLL reset is released. A fixed settling wait follows each step. After the last wait the block samples a synchronized lock-detect input a bounded number of times, with a fixed gap between samples. It ends with a one-cycle success pulse or a one-cycle timeout pulse, so the sequence never hangs.

A one-cycle stop request puts the PLL back into reset. The block then waits one settling period and gives a success pulse. The clock-enable bits and the select field are left alone on stop, and they also stay as they are after a timeout. Controlling software, or a later stage, decides what to do with them. The block only drives the control fields and samples the lock input. The analog PLL and any shared power gating are outside it.

Top module: `pcie_pll_seq`

## Requirements
- R1: After reset `refclk_sel_o` equals the parameter `SEL_RST` (default all ones). `clk_en_o`, `pll_rel_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A start request sampled in idle on clock edge E0 clears `refclk_sel_o` to 0 from E0 on. `busy_o` is 1 from E0 until the result pulse. `clk_en_o` and `pll_rel_o` do not change at E0.
- R3: At edge E0+STEP_WAIT all three bits of `clk_en_o` rise together, giving 3'b111. Bit 0 is the reference buffer enable, bit 1 the TX clock-reference enable and bit 2 the TX clock-reference select. Before that edge they keep their previous value.
- R4: At edge E0+2*STEP_WAIT `pll_rel_o` goes to 1. Before that edge it keeps its previous value.
- R5: Lock sample k (k = 0 .. POLL_MAX-1) is decided at edge E0+3*STEP_WAIT+1+k*(POLL_GAP+1). The first sample that sees lock produces `done_o` for the cycle after that edge.
- R6: `lock_i` passes through two flops before the sequencer sees it. If `lock_i` is first driven high so that edge X samples it, only samples decided at edge X+2 or later can see lock.
- R7: If none of the POLL_MAX samples sees lock, `timeout_o` pulses for the cycle after the edge of the last sample.
- R8: `done_o` and `timeout_o` are never high together, each lasts one cycle, and `busy_o` is 0 while they are high.
- R9: After a success or a timeout, `clk_en_o` stays 3'b111 and `pll_rel_o` stays 1 until a later stop or start changes them.
- R10: A stop request sampled in idle on edge E0 clears `pll_rel_o` from E0 on. `busy_o` stays 1 for STEP_WAIT cycles. `done_o` pulses after edge E0+STEP_WAIT. `clk_en_o` and `refclk_sel_o` are unchanged.
- R11: Start and stop requests are ignored while `busy_o` is 1. If start and stop arrive together in idle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Bring-up request (one cycle) |
| stop_i | input | 1 | Power-down request (one cycle) |
| lock_i | input | 1 | Asynchronous PLL lock detect |
| refclk_sel_o | output | SEL_W | Reference-clock select field |
| clk_en_o | output | 3 | Clock enables: [0] ref buffer, [1] TX ref enable, [2] TX ref select |
| pll_rel_o | output | 1 | PLL reset release (1 = out of reset) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| timeout_o | output | 1 | One-cycle lock-timeout pulse |

## Verification
The bench builds the block with STEP_WAIT=4, POLL_GAP=2 and POLL_MAX=5, so a complete bring-up lasts under thirty cycles. With these values the bench can raise lock at every cycle offset of the bring-up window, and also never raise it. For each case it works out from the poll schedule and the two-flop delay which sample should succeed, or that the timeout should fire. This covers the lock that arrives one cycle too late for a sample, lock on the very last sample, and lock raised before the poll starts. Power-down, requests made while busy, and simultaneous start and stop are run between these sweeps.

// File: rtl/pcie_pll_seq_pkg.sv
package pcie_pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_SEL,
        ST_W_CLK,
        ST_W_REL,
        ST_POLL,
        ST_POLL_WAIT,
        ST_W_OFF
    } seq_state_e;

    localparam int unsigned CLK_EN_W = 3;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[0] <= 1'b0;
                else        ff_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[i] <= 1'b0;
                else        ff_q[i] <= ff_q[i-1];
            end
        end
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R5: a reload is the only way the count can grow
    a_r5_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/pcie_pll_seq.sv
module pcie_pll_seq
    import pcie_pll_seq_pkg::*;
#(
    parameter int unsigned       STEP_WAIT = 10000,
    parameter int unsigned       POLL_GAP  = 1000,
    parameter int unsigned       POLL_MAX  = 100,
    parameter int unsigned       SEL_W     = 4,
    parameter logic [SEL_W-1:0]  SEL_RST   = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                lock_i,
    output logic [SEL_W-1:0]    refclk_sel_o,
    output logic [CLK_EN_W-1:0] clk_en_o,
    output logic                pll_rel_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                timeout_o
);
    localparam int unsigned TMAX        = (STEP_WAIT > POLL_GAP) ? STEP_WAIT : POLL_GAP;
    localparam int unsigned TW          = $clog2(TMAX + 1);
    localparam int unsigned PW          = $clog2(POLL_MAX + 1);
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        seq_state_e          st;
        logic [SEL_W-1:0]    sel;
        logic [CLK_EN_W-1:0] en;
        logic                rel;
        logic                done;
        logic                tmo;
        logic [PW-1:0]       polls;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic          lock_s;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (lock_i),
        .q_o   (lock_s)
    );

    pll_wait_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.sel  = '0;
                    r_d.st   = ST_W_SEL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STEP_WAIT - 1);
                end else if (stop_i) begin
                    r_d.rel  = 1'b0;
                    r_d.st   = ST_W_OFF;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STEP_WAIT - 1);
                end
            end
            ST_W_SEL: begin
                if (tmr_expired) begin
                    r_d.en   = '1;
                    r_d.st   = ST_W_CLK;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STEP_WAIT - 1);
                end
            end
            ST_W_CLK: begin
                if (tmr_expired) begin
                    r_d.rel  = 1'b1;
                    r_d.st   = ST_W_REL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STEP_WAIT - 1);
                end
            end
            ST_W_REL: begin
                if (tmr_expired) begin
                    r_d.polls = '0;
                    r_d.st    = ST_POLL;
                end
            end
            ST_POLL: begin
                if (lock_s) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (r_q.polls == PW'(POLL_MAX - 1)) begin
                    r_d.tmo  = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.polls = r_q.polls + 1'b1;
                    r_d.st    = ST_POLL_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(POLL_GAP - 1);
                end
            end
            ST_POLL_WAIT: begin
                if (tmr_expired) r_d.st = ST_POLL;
            end
            ST_W_OFF: begin
                if (tmr_expired) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.sel   <= SEL_RST;
            r_q.en    <= '0;
            r_q.rel   <= 1'b0;
            r_q.done  <= 1'b0;
            r_q.tmo   <= 1'b0;
            r_q.polls <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign refclk_sel_o = r_q.sel;
    assign clk_en_o     = r_q.en;
    assign pll_rel_o    = r_q.rel;
    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign timeout_o    = r_q.tmo;

    // R8: result pulses are exclusive and only seen in idle
    a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o) && !((done_o || timeout_o) && busy_o));

    // R3: clock enables change only when leaving the select-clear wait
    a_r3_en_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o != $past(clk_en_o)) |-> $past(r_q.st == ST_W_SEL && tmr_expired));

    // R4: reset release only follows enabled clocks
    a_r4_rel_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_rel_o) |-> (clk_en_o == '1));

    // R5: success from polling needs a synchronized lock on the deciding edge
    a_r5_done_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(r_q.st == ST_POLL)) |-> $past(lock_s));

    // R6: synchronized lock lags the pin by two edges
    a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        lock_s |-> $past(lock_i, 2));

    // R7: poll counter stays inside its bound
    a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.polls < PW'(POLL_MAX));

    // R11: requests while busy leave the select field alone
    a_r11_busy_sel: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(refclk_sel_o));
endmodule

// File: tb/sim_pcie_pll_seq.sv
module sim_pcie_pll_seq;
    localparam int S = 4;
    localparam int G = 2;
    localparam int M = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, lock_i = 1'b0;
    logic [3:0] refclk_sel_o;
    logic [2:0] clk_en_o;
    logic       pll_rel_o, busy_o, done_o, timeout_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pcie_pll_seq #(.STEP_WAIT(S), .POLL_GAP(G), .POLL_MAX(M), .SEL_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .lock_i(lock_i),
        .refclk_sel_o(refclk_sel_o), .clk_en_o(clk_en_o), .pll_rel_o(pll_rel_o),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // x: edge offset after which lock is raised (-1: never)
    // both: raise stop together with start; inject: requests while busy
    task automatic run_bringup(input int x, input bit both, input bit inject);
        int exp_c, got_c;
        bit exp_tmo, got_tmo;
        logic [2:0] en0;
        logic rel0;
        exp_c = -1; exp_tmo = 1'b1;
        for (int k = 0; k < M; k++) begin
            int d;
            d = 3*S + 1 + k*(G+1);
            if (x >= 0 && exp_c < 0 && d >= x + 3) begin exp_c = d; exp_tmo = 1'b0; end
        end
        if (exp_c < 0) exp_c = 3*S + 1 + (M-1)*(G+1);
        lock_i = 1'b0;
        repeat (3) @(negedge clk);
        en0 = clk_en_o; rel0 = pll_rel_o;
        start_i = 1'b1; stop_i = both;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        got_c = -1; got_tmo = 1'b0;
        for (int c = 0; c < 3*S + (M+1)*(G+1) + 4; c++) begin
            if (c == x) lock_i = 1'b1;
            if (inject && c == 2*S + 1) begin start_i = 1'b1; stop_i = 1'b1; end
            if (inject && c == 2*S + 2) begin start_i = 1'b0; stop_i = 1'b0; end
            if (c == 0) begin
                chk(refclk_sel_o == 4'd0, "R2 sel cleared", refclk_sel_o, 0);
                chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
                chk(clk_en_o == en0, "R2 en held", clk_en_o, en0);
                chk(pll_rel_o == rel0, "R2 rel held", pll_rel_o, rel0);
            end
            if (c == S - 1) chk(clk_en_o == en0, "R3 en before step", clk_en_o, en0);
            if (c == S) chk(clk_en_o == 3'b111, "R3 en set", clk_en_o, 7);
            if (c == 2*S - 1) chk(pll_rel_o == rel0, "R4 rel before step", pll_rel_o, rel0);
            if (c == 2*S) chk(pll_rel_o == 1'b1, "R4 rel set", pll_rel_o, 1);
            if (inject && c == 2*S + 3) begin
                chk(pll_rel_o == 1'b1, "R11 stop ignored busy", pll_rel_o, 1);
                chk(busy_o == 1'b1, "R11 still busy", busy_o, 1);
            end
            if (got_c < 0 && (done_o || timeout_o)) begin
                got_c = c; got_tmo = timeout_o;
                chk(!(done_o && timeout_o) && !busy_o, "R8 pulse exclusive idle",
                    {done_o, timeout_o, busy_o}, 3'b000 | {~exp_tmo, exp_tmo, 1'b0});
            end else if (got_c >= 0 && c == got_c + 1) begin
                chk(!done_o && !timeout_o, "R8 single cycle", {done_o, timeout_o}, 0);
                chk(clk_en_o == 3'b111, "R9 en kept", clk_en_o, 7);
                chk(pll_rel_o == 1'b1, "R9 rel kept", pll_rel_o, 1);
            end
            @(negedge clk);
        end
        if (exp_tmo) chk(got_c == exp_c && got_tmo, "R7 timeout edge", got_c, exp_c);
        else         chk(got_c == exp_c && !got_tmo, "R5 R6 done edge", got_c, exp_c);
        lock_i = 1'b0;
    endtask

    task automatic run_stop();
        logic [2:0] en0;
        logic [3:0] sel0;
        int got_c;
        repeat (2) @(negedge clk);
        en0 = clk_en_o; sel0 = refclk_sel_o;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        got_c = -1;
        for (int c = 0; c < S + 4; c++) begin
            if (c == 0) chk(pll_rel_o == 1'b0, "R10 rel cleared", pll_rel_o, 0);
            if (c == S - 1) chk(busy_o == 1'b1, "R10 busy in wait", busy_o, 1);
            if (c == 1) begin start_i = 1'b1; end
            if (c == 2) begin start_i = 1'b0; end
            if (got_c < 0 && done_o) got_c = c;
            chk(clk_en_o == en0 && refclk_sel_o == sel0, "R10 R11 fields unchanged",
                {clk_en_o, refclk_sel_o}, {en0, sel0});
            @(negedge clk);
        end
        chk(got_c == S, "R10 done edge", got_c, S);
    endtask

    initial begin
        #(10 * 50000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(refclk_sel_o == 4'hF, "R1 sel reset", refclk_sel_o, 15);
        chk(clk_en_o == 3'd0, "R1 en reset", clk_en_o, 0);
        chk(pll_rel_o == 1'b0, "R1 rel reset", pll_rel_o, 0);
        chk(!busy_o && !done_o && !timeout_o, "R1 status reset",
            {busy_o, done_o, timeout_o}, 0);
        // R11: simultaneous start and stop, start wins
        run_bringup(5, 1'b1, 1'b0);
        // R11: requests while busy are ignored
        run_bringup(-1, 1'b0, 1'b1);
        run_stop();
        // R5 R6 R7 sweep of lock arrival offsets
        for (int x = -1; x <= 3*S + 1 + (M-1)*(G+1) + 2; x++) begin
            run_bringup(x, 1'b0, 1'b0);
            if (x % 4 == 0) run_stop();
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule